// File: doc/BRIEF.md
# Sector Load Buffer and Program Timer

This block collects the byte writes that make up one sector reprogram. Program mode is opened by a one-cycle enable pulse from the command decoder. The first byte write after that pulse fixes the target sector. Further writes to the same sector are stored in a 256-entry staging buffer, in any order. Each entry has its own valid bit.

A counter measures the idle time after each accepted byte. When the counter reaches a parameterised limit with no new byte, the load window closes and a busy period starts, also of parameterised length. The controller then sweeps the sector twice in the behavioural memory array: first every byte is set to the erased value FF, then every byte is written with the staged value, or FF where nothing was staged. At the end of the busy period a one-cycle done pulse is issued.

Two lock inputs guard the boot regions at the bottom and top of the address space. Their value is sampled when the window closes. A locked sector keeps its contents, but the busy period still runs. The address and data of the last accepted byte are kept on output ports for the status logic. A read port gives access to the memory array.

The controller is a six-state machine:
- `ST_IDLE`: waiting. `ST_IDLE -> ST_ARMED` on the enable pulse.
- `ST_ARMED`: waiting for the first byte. `ST_ARMED -> ST_LOAD` on any write.
- `ST_LOAD`: collecting bytes. `ST_LOAD -> ST_ERASE` when the timeout expires.
- `ST_ERASE`: erase sweep. `ST_ERASE -> ST_WRITE` after byte offset 255.
- `ST_WRITE`: program sweep. `ST_WRITE -> ST_WAIT` after byte offset 255.
- `ST_WAIT`: waiting out the busy period. `ST_WAIT -> ST_IDLE` when the busy counter ends, together with the done pulse.

Top module: `sector_prog_engine`

## Requirements
- R1: An address splits into a sector number in bits [SECT_W+7:8] and a byte offset in bits [7:0]. Only the addressed byte of the addressed sector is affected by a write.
- R2: While no program enable pulse has been seen (idle), byte writes are ignored. They do not change `last_addr` or `last_data`, do not start a window and do not alter memory.
- R3: Bytes may arrive at any offsets in any order. If an offset is written twice in one load, the later value wins.
- R4: The first accepted byte fixes the sector. A write to a different sector during loading is ignored: it is not stored, does not update `last_addr`, and does not restart the inactivity timer.
- R5: `busy` rises in the cycle after the LOAD_TMO-th consecutive clock edge with no accepted byte. A same-sector byte sampled on exactly that edge is accepted instead and opens a new full window.
- R6: After a cycle on an unlocked sector, each loaded offset reads its staged value, every other offset of that sector reads FF, and other sectors are unchanged.
- R7: Lower boot region = sectors 0 to BOOT_SECT-1, guarded by `lock[0]`. Upper boot region = the last BOOT_SECT sectors, guarded by `lock[1]`. A guarded sector is left unchanged, and the busy period still runs for its full length. A lock bit does not affect the other region.
- R8: `busy` stays high for exactly PROG_CYC cycles. `done` is high for exactly one cycle, the first cycle in which `busy` is low again.
- R9: While busy, byte writes and enable pulses are ignored. After `done`, the block is idle and not armed.
- R10: `last_addr` and `last_data` hold the address and data of the most recently accepted byte.
- R11: After reset, `busy`, `done`, `last_addr` and `last_data` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| prog_en | input | 1 | One-cycle pulse that opens program mode |
| wr_valid | input | 1 | Byte write strobe |
| wr_addr | input | SECT_W+8 | Byte write address (sector and offset) |
| wr_data | input | 8 | Byte write data |
| lock | input | 2 | Boot region guards: bit 0 lower, bit 1 upper |
| rd_addr | input | SECT_W+8 | Memory array read address |
| rd_data | output | 8 | Memory array read data (combinational) |
| busy | output | 1 | Erase/program period in progress |
| done | output | 1 | One-cycle pulse at the end of the busy period |
| last_addr | output | SECT_W+8 | Address of the last accepted byte |
| last_data | output | 8 | Data of the last accepted byte |

## Verification
Two events can land on the same clock edge: the arrival of a byte and the expiry of the inactivity timeout. The bench provokes this by placing a byte write exactly LOAD_TMO edges after the previous accepted one.

With a same-sector byte, `busy` must stay low, that byte must appear in `last_addr` and later in memory, and a further full window must pass before the close. With a byte for a foreign sector on that edge, the window must still close on schedule. The foreign byte must leave no trace, either in `last_addr` or in the target sector contents read back after `done`.

// File: rtl/slb_pkg.sv
package slb_pkg;
    localparam int OFS_W  = 8;
    localparam int BYTE_W = 8;
    localparam int SECT_BYTES = 1 << OFS_W;
    localparam logic [BYTE_W-1:0] ERASED_VAL = 8'hFF;
    localparam logic [OFS_W-1:0]  LAST_OFS   = 8'hFF;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARMED,
        ST_LOAD,
        ST_ERASE,
        ST_WRITE,
        ST_WAIT
    } slb_state_e;
endpackage

// File: rtl/slb_buffer.sv
module slb_buffer
    import slb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              we,
    input  logic [OFS_W-1:0]  widx,
    input  logic [BYTE_W-1:0] wdata,
    input  logic [OFS_W-1:0]  ridx,
    output logic [BYTE_W-1:0] rdata,
    output logic              rvalid
);
    logic [BYTE_W-1:0] data_q  [SECT_BYTES];
    logic              valid_q [SECT_BYTES];

    always_ff @(posedge clk) begin
        if (we) begin
            data_q[widx] <= wdata;
        end
    end

    for (genvar gi = 0; gi < SECT_BYTES; gi++) begin : g_vld
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                valid_q[gi] <= 1'b0;
            end else if (clr) begin
                valid_q[gi] <= we && (widx == OFS_W'(gi));
            end else if (we && (widx == OFS_W'(gi))) begin
                valid_q[gi] <= 1'b1;
            end
        end
    end

    assign rdata  = data_q[ridx];
    assign rvalid = valid_q[ridx];
endmodule

// File: rtl/slb_array.sv
module slb_array #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            cells[waddr] <= wdata;
        end
    end

    assign rdata = cells[raddr];
endmodule

// File: rtl/slb_ctrl.sv
module slb_ctrl
    import slb_pkg::*;
#(
    parameter int SECT_W    = 3,
    parameter int BOOT_SECT = 1,
    parameter int LOAD_TMO  = 16,
    parameter int PROG_CYC  = 600
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  prog_en,
    input  logic                  wr_valid,
    input  logic [SECT_W+7:0]     wr_addr,
    input  logic [BYTE_W-1:0]     wr_data,
    input  logic [1:0]            lock,
    output logic                  busy,
    output logic                  done,
    output logic                  mem_we,
    output logic                  erase_ph,
    output logic                  buf_we,
    output logic                  buf_clr,
    output logic [OFS_W-1:0]      ptr,
    output logic [SECT_W-1:0]     sect,
    output logic [SECT_W+7:0]     last_addr,
    output logic [BYTE_W-1:0]     last_data
);
    localparam int ADDR_W = SECT_W + OFS_W;
    localparam int NSECT  = 1 << SECT_W;
    localparam int TMO_W  = $clog2(LOAD_TMO + 1);
    localparam int PC_W   = $clog2(PROG_CYC + 1);
    localparam logic [SECT_W-1:0] LO_END   = SECT_W'(BOOT_SECT);
    localparam logic [SECT_W-1:0] HI_START = SECT_W'(NSECT - BOOT_SECT);

    slb_state_e        state, next;
    logic [TMO_W-1:0]  idle_cnt;
    logic [PC_W-1:0]   prog_cnt;
    logic              locked_q;
    logic [SECT_W-1:0] wr_sect;
    logic              acc_first, acc_more, wr_acc, tmo_hit, locked_now;
    logic              in_sweep, sweep_end, prog_end;

    assign wr_sect   = wr_addr[ADDR_W-1:OFS_W];
    assign acc_first = (state == ST_ARMED) && wr_valid;
    assign acc_more  = (state == ST_LOAD) && wr_valid && (wr_sect == sect);
    assign wr_acc    = acc_first || acc_more;
    assign tmo_hit   = (state == ST_LOAD) && !acc_more
                       && (idle_cnt == TMO_W'(LOAD_TMO - 1));
    assign locked_now = ((sect < LO_END) && lock[0])
                        || ((sect >= HI_START) && lock[1]);
    assign in_sweep  = (state == ST_ERASE) || (state == ST_WRITE);
    assign sweep_end = (ptr == LAST_OFS);
    assign prog_end  = (prog_cnt == PC_W'(PROG_CYC - 1));

    // next-state logic
    always_comb begin
        next = state;
        unique case (state)
            ST_IDLE:  if (prog_en)   next = ST_ARMED;
            ST_ARMED: if (wr_valid)  next = ST_LOAD;
            ST_LOAD:  if (tmo_hit)   next = ST_ERASE;
            ST_ERASE: if (sweep_end) next = ST_WRITE;
            ST_WRITE: if (sweep_end) next = ST_WAIT;
            ST_WAIT:  if (prog_end)  next = ST_IDLE;
            default:                 next = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= next;
        end
    end

    // counters and captured load context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idle_cnt  <= '0;
            prog_cnt  <= '0;
            ptr       <= '0;
            sect      <= '0;
            locked_q  <= 1'b0;
            last_addr <= '0;
            last_data <= '0;
        end else begin
            if (wr_acc) begin
                idle_cnt  <= '0;
                last_addr <= wr_addr;
                last_data <= wr_data;
            end else if (state == ST_LOAD) begin
                idle_cnt <= idle_cnt + 1'b1;
            end
            if (acc_first) begin
                sect <= wr_sect;
            end
            if (tmo_hit) begin
                locked_q <= locked_now;
                ptr      <= '0;
                prog_cnt <= '0;
            end else begin
                if (in_sweep) begin
                    ptr <= ptr + 1'b1;
                end
                if (busy) begin
                    prog_cnt <= prog_cnt + 1'b1;
                end
            end
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy <= 1'b0;
            done <= 1'b0;
        end else begin
            busy <= (next == ST_ERASE) || (next == ST_WRITE) || (next == ST_WAIT);
            done <= (state == ST_WAIT) && (next == ST_IDLE);
        end
    end

    assign mem_we   = in_sweep && !locked_q;
    assign erase_ph = (state == ST_ERASE);
    assign buf_we   = wr_acc;
    assign buf_clr  = acc_first;

    assert_done_ends_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));
    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_idle_ignores_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && wr_valid) |=> ($stable(last_addr) && $stable(last_data)));
    assert_busy_ignores_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr_valid) |=> $stable(last_addr));
    assert_foreign_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOAD && wr_valid && wr_sect != sect) |=> $stable(last_addr));
    assert_first_latch_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ARMED && wr_valid) |=> (last_addr == $past(wr_addr)));
endmodule

// File: rtl/sector_prog_engine.sv
module sector_prog_engine
    import slb_pkg::*;
#(
    parameter int SECT_W    = 3,
    parameter int BOOT_SECT = 1,
    parameter int LOAD_TMO  = 16,
    parameter int PROG_CYC  = 600
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog_en,
    input  logic              wr_valid,
    input  logic [SECT_W+7:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [1:0]        lock,
    input  logic [SECT_W+7:0] rd_addr,
    output logic [7:0]        rd_data,
    output logic              busy,
    output logic              done,
    output logic [SECT_W+7:0] last_addr,
    output logic [7:0]        last_data
);
    localparam int ADDR_W = SECT_W + OFS_W;

    logic              mem_we, erase_ph, buf_we, buf_clr, buf_rvalid;
    logic [OFS_W-1:0]  ptr;
    logic [SECT_W-1:0] sect;
    logic [BYTE_W-1:0] buf_rdata, mem_wdata;
    logic [ADDR_W-1:0] mem_waddr;

    slb_ctrl #(
        .SECT_W(SECT_W), .BOOT_SECT(BOOT_SECT),
        .LOAD_TMO(LOAD_TMO), .PROG_CYC(PROG_CYC)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .prog_en(prog_en),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data), .lock(lock),
        .busy(busy), .done(done), .mem_we(mem_we), .erase_ph(erase_ph),
        .buf_we(buf_we), .buf_clr(buf_clr), .ptr(ptr), .sect(sect),
        .last_addr(last_addr), .last_data(last_data)
    );

    slb_buffer u_buf (
        .clk(clk), .rst_n(rst_n), .clr(buf_clr), .we(buf_we),
        .widx(wr_addr[OFS_W-1:0]), .wdata(wr_data),
        .ridx(ptr), .rdata(buf_rdata), .rvalid(buf_rvalid)
    );

    assign mem_waddr = {sect, ptr};
    assign mem_wdata = (erase_ph || !buf_rvalid) ? ERASED_VAL : buf_rdata;

    slb_array #(.ADDR_W(ADDR_W), .DATA_W(BYTE_W)) u_mem (
        .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
        .raddr(rd_addr), .rdata(rd_data)
    );

    assert_buf_quiet_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !buf_we);
    assert_mem_only_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> busy);
endmodule

// File: tb/tb_sector_prog_engine.sv
`timescale 1ns/1ps
module tb_sector_prog_engine;
    localparam int SECT_W = 3, BOOT_SECT = 1, LOAD_TMO = 16, PROG_CYC = 600;
    localparam int AW = SECT_W + 8;
    localparam int NSECT = 1 << SECT_W;
    localparam int DEPTH = 1 << AW;

    logic clk = 0, rst_n = 0, prog_en = 0, wr_valid = 0;
    logic [AW-1:0] wr_addr = '0, rd_addr = '0;
    logic [7:0] wr_data = '0;
    logic [1:0] lock = 2'b00;
    logic [7:0] rd_data, last_data;
    logic busy, done;
    logic [AW-1:0] last_addr;

    int checks = 0, errors = 0;
    logic [7:0] model [DEPTH];
    bit known [DEPTH];
    bit ld_val [256];
    logic [7:0] ld_dat [256];
    logic [AW-1:0] exp_la;
    logic [7:0] exp_ld;

    always #2.5 clk = ~clk;

    sector_prog_engine #(.SECT_W(SECT_W), .BOOT_SECT(BOOT_SECT),
        .LOAD_TMO(LOAD_TMO), .PROG_CYC(PROG_CYC)) dut (
        .clk(clk), .rst_n(rst_n), .prog_en(prog_en), .wr_valid(wr_valid),
        .wr_addr(wr_addr), .wr_data(wr_data), .lock(lock), .rd_addr(rd_addr),
        .rd_data(rd_data), .busy(busy), .done(done),
        .last_addr(last_addr), .last_data(last_data));

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic gap(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_write(input logic [AW-1:0] a, input logic [7:0] d);
        wr_valid = 1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_valid = 0;
    endtask

    task automatic arm();
        prog_en = 1;
        @(negedge clk);
        prog_en = 0;
    endtask

    function automatic logic [7:0] expect_byte(input int ofs);
        return ld_val[ofs] ? ld_dat[ofs] : 8'hFF;
    endfunction

    task automatic commit_model(input int sec);
        for (int i = 0; i < 256; i++) begin
            model[sec*256 + i] = expect_byte(i);
            known[sec*256 + i] = 1;
        end
    endtask

    task automatic verify_sector(input int sec, input string tag);
        for (int i = 0; i < 256; i++) begin
            if (known[sec*256 + i]) begin
                rd_addr = AW'(sec*256 + i);
                #1;
                chk(tag, int'(rd_data), int'(model[sec*256 + i]));
            end
        end
    endtask

    task automatic wait_done(input bit inject);
        int cnt = 0;
        while (busy === 1'b1) begin
            cnt++;
            if (inject && cnt == 20) begin
                prog_en = 1; wr_valid = 1;
                wr_addr = AW'(exp_la + 1); wr_data = 8'h3C;
            end else begin
                prog_en = 0; wr_valid = 0;
            end
            @(negedge clk);
        end
        prog_en = 0; wr_valid = 0;
        chk("R8 busy length", cnt, PROG_CYC);
        chk("R8 done with busy fall", int'(done), 1);
        @(negedge clk);
        chk("R8 done single cycle", int'(done), 0);
        if (inject) begin
            chk("R9 last_addr after busy write", int'(last_addr), int'(exp_la));
            do_write(exp_la, 8'h11);
            gap(LOAD_TMO + 3);
            chk("R9 enable during busy ignored", int'(busy), 0);
            chk("R9 last_data untouched", int'(last_data), int'(exp_ld));
        end
    endtask

    task automatic round(input int sec, input bit locked, input bit inject, input string tag);
        int n;
        for (int i = 0; i < 256; i++) ld_val[i] = 0;
        arm();
        n = $urandom_range(1, 40);
        for (int k = 0; k < n; k++) begin
            logic [7:0] ofs, d;
            ofs = 8'($urandom_range(0, 255));
            d = 8'($urandom_range(0, 255));
            if (k > 0) begin
                gap($urandom_range(0, LOAD_TMO - 5));
                if ($urandom_range(0, 3) == 0)
                    do_write({SECT_W'((sec + 1) % NSECT), ofs}, ~d);
            end
            do_write({SECT_W'(sec), ofs}, d);
            ld_val[ofs] = 1; ld_dat[ofs] = d;
            exp_la = {SECT_W'(sec), ofs}; exp_ld = d;
        end
        gap(LOAD_TMO - 1);
        chk("R5 window still open", int'(busy), 0);
        gap(1);
        chk("R5 window closed", int'(busy), 1);
        chk("R10 last_addr", int'(last_addr), int'(exp_la));
        chk("R10 last_data", int'(last_data), int'(exp_ld));
        wait_done(inject);
        if (!locked) commit_model(sec);
        verify_sector(sec, tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd24681));
        for (int i = 0; i < DEPTH; i++) known[i] = 0;
        gap(4);
        chk("R11 busy reset", int'(busy), 0);
        chk("R11 done reset", int'(done), 0);
        rst_n = 1;
        gap(1);
        chk("R11 last_addr reset", int'(last_addr), 0);
        chk("R11 last_data reset", int'(last_data), 0);

        // R2: write without enable pulse
        do_write(AW'(16'h0345), 8'h5A);
        gap(LOAD_TMO + 3);
        chk("R2 no window", int'(busy), 0);
        chk("R2 last_addr", int'(last_addr), 0);

        // R1 R3 R6 R9: random loads, first one with busy-time injection
        round(3, 0, 1, "R6 sector 3 contents");
        round(4, 0, 0, "R1 R3 sector 4 contents");
        round(int'($urandom_range(1, NSECT - 2)), 0, 0, "R6 random sector");

        // R5 R4: collisions at the expiry edge
        for (int i = 0; i < 256; i++) ld_val[i] = 0;
        arm();
        do_write({SECT_W'(2), 8'd5}, 8'hA1);
        ld_val[5] = 1; ld_dat[5] = 8'hA1;
        gap(LOAD_TMO - 1);
        do_write({SECT_W'(2), 8'd9}, 8'hB2);
        ld_val[9] = 1; ld_dat[9] = 8'hB2;
        exp_la = {SECT_W'(2), 8'd9}; exp_ld = 8'hB2;
        chk("R5 same-sector write at expiry keeps window", int'(busy), 0);
        gap(LOAD_TMO - 1);
        chk("R5 renewed window open", int'(busy), 0);
        do_write({SECT_W'(5), 8'd9}, 8'hC3);
        chk("R4 foreign write at expiry does not hold window", int'(busy), 1);
        chk("R4 foreign write not latched", int'(last_addr), int'(exp_la));
        wait_done(0);
        commit_model(2);
        verify_sector(2, "R4 R5 sector 2 contents");

        // R7: lower boot region
        round(0, 0, 0, "R6 sector 0 first program");
        lock = 2'b01;
        round(0, 1, 0, "R7 lower locked unchanged");
        // R7: upper boot region, other bit set
        lock = 2'b00;
        round(NSECT - 1, 0, 0, "R6 top sector first program");
        lock = 2'b10;
        round(NSECT - 1, 1, 0, "R7 upper locked unchanged");
        round(0, 0, 0, "R7 lower free under upper lock");
        verify_sector(3, "R6 other sector unchanged");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule